// File: doc/BRIEF.md
# Serial NOR Flash Command Emulator

This block models the slave side of a serial NOR flash device in synthesizable logic. It receives opcodes, a 24-bit address and write-data bytes over a simple strobe interface and returns read-data beats. It is meant to stand in for a real flash part in system tests. The storage array is a small parameterized byte memory, and the serial pin layer is not modelled. A write-enable latch guards every program and every erase. Erases run as a sweep that clears one byte per clock, and a busy flag stays high while a sweep runs.

The host starts a transaction by pulsing `cmd_valid` with `cmd_op` and `cmd_addr`. For data commands it then pulses `rd_req` once per read beat or `wr_valid` once per write byte, and it closes the transaction with `txn_end`. Single-byte commands need no `txn_end`: these are write enable, write disable and the three erases. Read beats appear on `rd_data` with `rd_valid` one clock after `rd_req`.

The controller is a state machine with these states:
- ST_IDLE: accepts a command when not busy.
- ST_IDENT: identification beats.
- ST_STATUS: status beats.
- ST_READ: array read.
- ST_PROG: page program.
- ST_SINK: unrecognized opcode.

Its transitions are:
- ST_IDLE to ST_IDENT on 0x9F.
- ST_IDLE to ST_STATUS on 0x05.
- ST_IDLE to ST_READ on 0x03 or 0xEB.
- ST_IDLE to ST_PROG on 0x02.
- ST_IDLE to ST_SINK on any other opcode that is not one of the single-byte commands.
- ST_IDLE back to ST_IDLE on 0x06, 0x04, 0x20, 0xD8 and 0xC7.
- Every data state back to ST_IDLE on `txn_end`.

Top module: `nor_cmd_emu`

## Requirements
- R1: After reset the erase sweep clears the whole array of 2^MEM_AW bytes to 0xFF with `busy` high for exactly 2^MEM_AW clocks. The write-enable latch is clear and `last_op` reads 0xFF.
- R2: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Every read beat of opcode 0x05 returns 0x02 while the latch is set and 0x00 while it is clear.
- R3: Opcode 0x9F returns 0x20, then 0xBA, then CAP_CODE (default 0x18). Any further beat returns 0xFF.
- R4: Opcodes 0x03 and 0xEB return array bytes starting at the given address. The address increments per beat and wraps at the array end. Opcode 0xEB also clears the write-enable latch.
- R5: Opcode 0x02 writes each data byte at the current address while the latch is set. The low 8 address bits increment and wrap inside the 256-byte page, and the bits above stay fixed. With the latch clear, the data bytes are dropped.
- R6: Opcode 0x20 aligns the address down to 2^SUB_AW bytes and fills that span with 0xFF. Opcode 0xD8 does the same with 2^SEC_AW bytes. Each span is capped at the array size.
- R7: Opcode 0xC7 fills the whole array with 0xFF.
- R8: An erase opcode with the latch clear changes no byte and does not raise `busy`.
- R9: An accepted erase raises `busy` on the next clock and holds it for one clock per byte cleared. A command that arrives while `busy` is high is ignored, and `last_op` keeps its value.
- R10: An unrecognized opcode changes neither the latch nor the array, and its read beats return 0xFF. `last_op` records every accepted opcode.
- R11: `rd_valid` and `rd_data` follow `rd_req` by one clock. A beat requested outside a read-type command returns 0xFF.
- R12: Address bits at and above MEM_AW are ignored, so addresses that differ only in those bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Opcode strobe |
| cmd_op | input | 8 | Opcode |
| cmd_addr | input | 24 | Command address |
| wr_valid | input | 1 | Write-data byte strobe |
| wr_data | input | 8 | Write-data byte |
| rd_req | input | 1 | Read-beat request |
| txn_end | input | 1 | Ends the current data command |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | 8 | Read beat data |
| busy | output | 1 | Erase sweep in progress |
| last_op | output | 8 | Most recently accepted opcode |

## Verification
A behavioural reference model in the bench tracks the latch, the byte array and the transaction state. On every clock it is compared against `busy`, `last_op` and the read beats.

Reads are tried at page ends, across the array end and through aliased upper address bits. These separate page-wrap from linear increment and show whether high address bits leak into the array index. Programs are issued once with the latch set and once with it clear. Each erase type is aimed at an unaligned address beside data that sits just outside its span, which exposes wrong alignment or a wrong span length. Commands sent during a sweep, and erases sent with the latch clear, show whether the latch and the busy gate block what they should.

// File: rtl/nor_emu_pkg.sv
package nor_emu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IDENT,
        ST_STATUS,
        ST_READ,
        ST_PROG,
        ST_SINK
    } ctl_state_t;

    typedef enum logic [1:0] {
        SPAN_SUB,
        SPAN_SEC,
        SPAN_ALL
    } span_t;

    localparam logic [7:0] OP_WEN   = 8'h06;
    localparam logic [7:0] OP_WDIS  = 8'h04;
    localparam logic [7:0] OP_IDENT = 8'h9F;
    localparam logic [7:0] OP_STAT  = 8'h05;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_QREAD = 8'hEB;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_SSUB  = 8'h20;
    localparam logic [7:0] OP_SSEC  = 8'hD8;
    localparam logic [7:0] OP_BULK  = 8'hC7;

    localparam logic [7:0] ERASED   = 8'hFF;
    localparam logic [7:0] WEL_BIT  = 8'h02;
    localparam logic [7:0] ID_MFR   = 8'h20;
    localparam logic [7:0] ID_TYPE  = 8'hBA;

endpackage

// File: rtl/nor_emu_store.sv
module nor_emu_store #(
    parameter int MEM_AW = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [MEM_AW-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/nor_emu_sweep.sv
module nor_emu_sweep
    import nor_emu_pkg::*;
#(
    parameter int MEM_AW = 11,
    parameter int SUB_AW = 8,
    parameter int SEC_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  span_t             span,
    input  logic [MEM_AW-1:0] base,
    output logic              active,
    output logic              we,
    output logic [MEM_AW-1:0] waddr
);
    localparam int SUB_EFF = (SUB_AW < MEM_AW) ? SUB_AW : MEM_AW;
    localparam int SEC_EFF = (SEC_AW < MEM_AW) ? SEC_AW : MEM_AW;
    localparam int CW      = MEM_AW + 1;
    localparam logic [CW-1:0] FULL = CW'(1) << MEM_AW;

    logic [MEM_AW-1:0] ptr_q;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     len;
    logic [MEM_AW-1:0] mask;

    always_comb begin
        unique case (span)
            SPAN_SUB: begin
                len  = CW'(1) << SUB_EFF;
                mask = ~((MEM_AW'(1) << SUB_EFF) - MEM_AW'(1));
            end
            SPAN_SEC: begin
                len  = CW'(1) << SEC_EFF;
                mask = ~((MEM_AW'(1) << SEC_EFF) - MEM_AW'(1));
            end
            default: begin
                len  = FULL;
                mask = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b1;
            ptr_q  <= '0;
            cnt_q  <= FULL;
        end else if (active) begin
            ptr_q <= ptr_q + MEM_AW'(1);
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
                active <= 1'b0;
            end
        end else if (start) begin
            active <= 1'b1;
            ptr_q  <= base & mask;
            cnt_q  <= len;
        end
    end

    assign we    = active;
    assign waddr = ptr_q;

    // R9: a running sweep always has bytes left to clear
    a_r9_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q != '0));

    // R6: a sweep never starts off its span boundary
    a_r6_aligned_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && start && span == SPAN_SUB) |=>
            (ptr_q[(SUB_EFF > 0 ? SUB_EFF : 1)-1:0] == '0));

endmodule

// File: rtl/nor_emu_ctrl.sv
module nor_emu_ctrl
    import nor_emu_pkg::*;
#(
    parameter int         MEM_AW   = 11,
    parameter logic [7:0] CAP_CODE = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [MEM_AW-1:0] cmd_addr,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              rd_req,
    input  logic              txn_end,
    input  logic              busy,
    output logic [7:0]        last_op,
    output logic              wel,
    output logic              rd_valid,
    output logic              rd_from_mem,
    output logic [7:0]        rd_const,
    output logic [MEM_AW-1:0] mem_raddr,
    output logic              pp_we,
    output logic [MEM_AW-1:0] pp_waddr,
    output logic [7:0]        pp_wdata,
    output logic              erase_start,
    output span_t             erase_span,
    output logic [MEM_AW-1:0] erase_base
);
    localparam int PW = MEM_AW - 8;

    ctl_state_t        state_q, state_d;
    logic              accept;
    logic              is_erase;
    logic [MEM_AW-1:0] ptr_q;
    logic [PW-1:0]     page_q;
    logic [7:0]        low_q;
    logic [1:0]        idx_q;

    function automatic logic [7:0] id_byte(input logic [1:0] i);
        case (i)
            2'd0:    id_byte = ID_MFR;
            2'd1:    id_byte = ID_TYPE;
            2'd2:    id_byte = CAP_CODE;
            default: id_byte = ERASED;
        endcase
    endfunction

    assign accept   = (state_q == ST_IDLE) && cmd_valid && !busy;
    assign is_erase = (cmd_op == OP_SSUB) || (cmd_op == OP_SSEC) || (cmd_op == OP_BULK);

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    case (cmd_op)
                        OP_IDENT:         state_d = ST_IDENT;
                        OP_STAT:          state_d = ST_STATUS;
                        OP_READ, OP_QREAD: state_d = ST_READ;
                        OP_PROG:          state_d = ST_PROG;
                        OP_WEN, OP_WDIS,
                        OP_SSUB, OP_SSEC,
                        OP_BULK:          state_d = ST_IDLE;
                        default:          state_d = ST_SINK;
                    endcase
                end
            end
            ST_IDENT, ST_STATUS, ST_READ, ST_PROG, ST_SINK: begin
                if (txn_end) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel         <= 1'b0;
            last_op     <= ERASED;
            ptr_q       <= '0;
            page_q      <= '0;
            low_q       <= '0;
            idx_q       <= '0;
            rd_valid    <= 1'b0;
            rd_from_mem <= 1'b0;
            rd_const    <= ERASED;
        end else begin
            rd_valid    <= rd_req;
            rd_from_mem <= 1'b0;
            if (accept) begin
                last_op <= cmd_op;
                case (cmd_op)
                    OP_WEN:   wel <= 1'b1;
                    OP_WDIS:  wel <= 1'b0;
                    OP_QREAD: begin
                        wel   <= 1'b0;
                        ptr_q <= cmd_addr;
                    end
                    OP_READ:  ptr_q <= cmd_addr;
                    OP_PROG: begin
                        page_q <= cmd_addr[MEM_AW-1:8];
                        low_q  <= cmd_addr[7:0];
                    end
                    OP_IDENT: idx_q <= '0;
                    default: ;
                endcase
            end
            if (rd_req) begin
                rd_const <= ERASED;
                unique case (state_q)
                    ST_IDENT: begin
                        rd_const <= id_byte(idx_q);
                        if (idx_q != 2'd3) begin
                            idx_q <= idx_q + 2'd1;
                        end
                    end
                    ST_STATUS: rd_const <= wel ? WEL_BIT : 8'h00;
                    ST_READ: begin
                        rd_from_mem <= 1'b1;
                        ptr_q       <= ptr_q + MEM_AW'(1);
                    end
                    default: ;
                endcase
            end
            if (state_q == ST_PROG && wr_valid) begin
                low_q <= low_q + 8'd1;
            end
        end
    end

    assign mem_raddr   = ptr_q;
    assign pp_we       = (state_q == ST_PROG) && wr_valid && wel;
    assign pp_waddr    = {page_q, low_q};
    assign pp_wdata    = wr_data;
    assign erase_start = accept && is_erase && wel;
    assign erase_base  = cmd_addr;

    always_comb begin
        case (cmd_op)
            OP_SSUB: erase_span = SPAN_SUB;
            OP_SSEC: erase_span = SPAN_SEC;
            default: erase_span = SPAN_ALL;
        endcase
    end

    // R4: the quad read drops the write-enable latch
    a_r4_qread_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == OP_QREAD) |=> !wel);

    // R9: a command offered during a sweep leaves the opcode record alone
    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(last_op));

    // R10: an unknown opcode does not touch the latch
    a_r10_sink_keeps_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && state_d == ST_SINK) |=> $stable(wel));

    // R5: the page bits hold while a program runs
    a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && state_d == ST_PROG) |=> $stable(page_q));

endmodule

// File: rtl/nor_cmd_emu.sv
module nor_cmd_emu
    import nor_emu_pkg::*;
#(
    parameter int         MEM_AW   = 11,
    parameter int         SUB_AW   = 8,
    parameter int         SEC_AW   = 10,
    parameter logic [7:0] CAP_CODE = 8'h18
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_op,
    input  logic [23:0] cmd_addr,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    input  logic        rd_req,
    input  logic        txn_end,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        busy,
    output logic [7:0]  last_op
);
    logic              sw_active, sw_we;
    logic [MEM_AW-1:0] sw_waddr;
    logic              wel;
    logic              rd_from_mem;
    logic [7:0]        rd_const;
    logic [MEM_AW-1:0] mem_raddr;
    logic              pp_we;
    logic [MEM_AW-1:0] pp_waddr;
    logic [7:0]        pp_wdata;
    logic              erase_start;
    span_t             erase_span;
    logic [MEM_AW-1:0] erase_base;
    logic              st_we;
    logic [MEM_AW-1:0] st_waddr;
    logic [7:0]        st_wdata;
    logic [7:0]        st_rdata;

    nor_emu_ctrl #(
        .MEM_AW   (MEM_AW),
        .CAP_CODE (CAP_CODE)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_addr    (cmd_addr[MEM_AW-1:0]),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .rd_req      (rd_req),
        .txn_end     (txn_end),
        .busy        (sw_active),
        .last_op     (last_op),
        .wel         (wel),
        .rd_valid    (rd_valid),
        .rd_from_mem (rd_from_mem),
        .rd_const    (rd_const),
        .mem_raddr   (mem_raddr),
        .pp_we       (pp_we),
        .pp_waddr    (pp_waddr),
        .pp_wdata    (pp_wdata),
        .erase_start (erase_start),
        .erase_span  (erase_span),
        .erase_base  (erase_base)
    );

    nor_emu_sweep #(
        .MEM_AW (MEM_AW),
        .SUB_AW (SUB_AW),
        .SEC_AW (SEC_AW)
    ) u_sweep (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (erase_start),
        .span   (erase_span),
        .base   (erase_base),
        .active (sw_active),
        .we     (sw_we),
        .waddr  (sw_waddr)
    );

    assign st_we    = sw_we | pp_we;
    assign st_waddr = sw_we ? sw_waddr : pp_waddr;
    assign st_wdata = sw_we ? ERASED : pp_wdata;

    nor_emu_store #(
        .MEM_AW (MEM_AW)
    ) u_store (
        .clk   (clk),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata),
        .raddr (mem_raddr),
        .rdata (st_rdata)
    );

    assign rd_data = rd_from_mem ? st_rdata : rd_const;
    assign busy    = sw_active;

    // R5: outside a sweep the array is written only with the latch set
    a_r5_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && !sw_active) |-> wel);

    // R8: a sweep only begins after the latch was set
    a_r8_erase_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_active) |-> $past(wel));

    // R9: sweep and program never share a write cycle
    a_r9_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_we && pp_we));

endmodule

// File: tb/nor_cmd_emu_bench.sv
module nor_cmd_emu_bench;
    localparam int DEPTH = 2048;
    localparam int SUB   = 256;
    localparam int SEC   = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic [23:0] cmd_addr = 24'h0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        rd_req = 1'b0;
    logic        txn_end = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        busy;
    logic [7:0]  last_op;

    always #5 clk = ~clk;

    nor_cmd_emu u_nor_cmd_emu (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .rd_req    (rd_req),
        .txn_end   (txn_end),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .busy      (busy),
        .last_op   (last_op)
    );

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // reference model state
    int         m_mode = 0;   // 0 idle, 1 ident, 2 status, 3 read, 4 program, 5 sink
    int         m_busy = DEPTH;
    int         m_wel = 0;
    logic [7:0] m_last = 8'hFF;
    int         m_ptr = 0, m_page = 0, m_low = 0, m_idx = 0;
    bit         e_rv = 1'b0;
    logic [7:0] e_rd = 8'hFF;
    logic [7:0] m_mem [DEPTH];
    int         ob, a;

    task automatic fill(input int base, input int n);
        for (int i = 0; i < n; i++) m_mem[(base + i) % DEPTH] = 8'hFF;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_busy = DEPTH; m_wel = 0; m_last = 8'hFF;
            m_ptr = 0; m_page = 0; m_low = 0; m_idx = 0; e_rv = 1'b0;
            fill(0, DEPTH);
        end else begin
            ob = m_busy;
            if (m_busy > 0) m_busy--;
            e_rv = rd_req;
            if (rd_req) e_rd = 8'hFF;
            if (m_mode == 0) begin
                if (cmd_valid && ob == 0) begin
                    m_last = cmd_op;
                    a = int'(cmd_addr) % DEPTH;
                    case (cmd_op)
                        8'h06: m_wel = 1;
                        8'h04: m_wel = 0;
                        8'h9F: begin m_mode = 1; m_idx = 0; end
                        8'h05: m_mode = 2;
                        8'h03: begin m_mode = 3; m_ptr = a; end
                        8'hEB: begin m_mode = 3; m_ptr = a; m_wel = 0; end
                        8'h02: begin m_mode = 4; m_page = a / 256; m_low = a % 256; end
                        8'h20: if (m_wel != 0) begin fill(a - a % SUB, SUB); m_busy = SUB; end
                        8'hD8: if (m_wel != 0) begin fill(a - a % SEC, SEC); m_busy = SEC; end
                        8'hC7: if (m_wel != 0) begin fill(0, DEPTH); m_busy = DEPTH; end
                        default: m_mode = 5;
                    endcase
                end
            end else if (txn_end) begin
                m_mode = 0;
            end else begin
                if (rd_req) begin
                    case (m_mode)
                        1: begin
                            e_rd = (m_idx == 0) ? 8'h20 : (m_idx == 1) ? 8'hBA :
                                   (m_idx == 2) ? 8'h18 : 8'hFF;
                            if (m_idx < 3) m_idx++;
                        end
                        2: e_rd = (m_wel != 0) ? 8'h02 : 8'h00;
                        3: begin e_rd = m_mem[m_ptr]; m_ptr = (m_ptr + 1) % DEPTH; end
                        default: ;
                    endcase
                end
                if (m_mode == 4 && wr_valid) begin
                    if (m_wel != 0) m_mem[m_page * 256 + m_low] = wr_data;
                    m_low = (m_low + 1) % 256;
                end
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("busy", 32'(busy), 32'(m_busy > 0));
            chk("last_op", 32'(last_op), 32'(m_last));
            chk("rd_valid", 32'(rd_valid), 32'(e_rv));
            if (e_rv) chk("rd_data", 32'(rd_data), 32'(e_rd));
        end
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic cmd(input logic [7:0] op, input logic [23:0] ad);
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_addr = ad;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic endt();
        @(negedge clk); txn_end = 1'b1;
        @(negedge clk); txn_end = 1'b0;
    endtask

    task automatic rd(input int n);
        @(negedge clk); rd_req = 1'b1;
        repeat (n) @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic wrn(input int n, input logic [7:0] seed);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1; wr_data = seed + 8'(i);
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic rdtxn(input logic [7:0] op, input logic [23:0] ad, input int n);
        cmd(op, ad); rd(n); endt();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        wait_idle();
        rdtxn(8'h03, 24'h000000, 3);
        rdtxn(8'h03, 24'h0007FE, 2);
        rdtxn(8'h05, 24'h0, 1);

        cur_req = "R2";
        cmd(8'h06, 24'h0);
        rdtxn(8'h05, 24'h0, 2);
        cmd(8'h04, 24'h0);
        rdtxn(8'h05, 24'h0, 2);

        cur_req = "R3";
        rdtxn(8'h9F, 24'h0, 5);

        cur_req = "R5";
        cmd(8'h06, 24'h0);
        cmd(8'h02, 24'h0001FE); wrn(4, 8'hA0); endt();
        rdtxn(8'h03, 24'h0001FE, 2);
        rdtxn(8'h03, 24'h000100, 3);
        cmd(8'h02, 24'h0000FE); wrn(2, 8'h50); endt();
        cmd(8'h02, 24'h000400); wrn(3, 8'h70); endt();
        cmd(8'h04, 24'h0);
        cmd(8'h02, 24'h000300); wrn(3, 8'h11); endt();
        rdtxn(8'h03, 24'h000300, 3);

        cur_req = "R4";
        cmd(8'h06, 24'h0);
        rdtxn(8'hEB, 24'h0001FE, 3);
        rdtxn(8'h05, 24'h0, 1);
        cmd(8'h06, 24'h0);
        rdtxn(8'h03, 24'h0007FF, 3);
        rdtxn(8'h05, 24'h0, 1);

        cur_req = "R12";
        rdtxn(8'h03, 24'h0409FE, 3);

        cur_req = "R8";
        cmd(8'h04, 24'h0);
        cmd(8'h20, 24'h000150);
        cmd(8'hD8, 24'h000150);
        cmd(8'hC7, 24'h0);
        rdtxn(8'h03, 24'h0001FE, 2);

        cur_req = "R6";
        cmd(8'h06, 24'h0);
        cmd(8'h20, 24'h0001F0);
        wait_idle();
        rdtxn(8'h03, 24'h0000FE, 4);
        rdtxn(8'h03, 24'h0003FF, 2);

        cur_req = "R9";
        cmd(8'hD8, 24'h000234);
        cmd(8'h04, 24'h0);
        cmd(8'h9F, 24'h0);
        wait_idle();
        rdtxn(8'h05, 24'h0, 1);
        rdtxn(8'h03, 24'h0003FE, 4);

        cur_req = "R10";
        cmd(8'h02, 24'h000600); wrn(2, 8'h33); endt();
        rdtxn(8'h77, 24'h000600, 2);
        rdtxn(8'h05, 24'h0, 1);
        rdtxn(8'h03, 24'h000600, 2);

        cur_req = "R11";
        rd(2);
        cmd(8'h02, 24'h000700); rd(1); endt();

        cur_req = "R7";
        cmd(8'hC7, 24'h0);
        wait_idle();
        rdtxn(8'h03, 24'h000600, 2);
        rdtxn(8'h03, 24'h000401, 1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog %s act=hung exp=finished", cur_req);
            report();
        end
    end

endmodule